// File: doc/BRIEF.md
# Clock-Stop Sleep State Controller

This block tracks the power state of a processor core and turns it into per-unit clock enables. It has three states: Running, Stop-Grant and Sleep. A stop-clock request takes the core from Running into Stop-Grant, which stops the core clock. From Stop-Grant only, a sleep request takes it further into Sleep. In Sleep the clocks to the bus unit, the interrupt-controller unit and the core are all off, and only the PLL enable stays high.

The same state decides whether incoming snoop and interrupt strobes are recognised. A recognised strobe comes out as a qualified pulse one cycle later. A strobe that arrives during Sleep is dropped and is not kept for later. Every clock enable and qualified pulse is a flop output, so it changes only on a rising clock edge.

Top module: `slp_sleep_ctrl`

## Requirements
- R1: A synchronous active-high reset, taken from any state, sets `state_o` to Running (code 2'b00). At the same edge it drives all four clock enables to 1 and both qualified-strobe outputs to 0.
- R2: In Running with `stpclk_req` high, the next edge moves `state_o` to Stop-Grant (code 2'b01). `core_clk_en` falls one edge after that, while `bus_clk_en` and `apic_clk_en` stay at 1.
- R3: In Running, `sleep_req` has no effect, and with `stpclk_req` low the state stays Running.
- R4: In Stop-Grant with `stpclk_req` high and `sleep_req` high, the next edge moves `state_o` to Sleep (code 2'b10). One edge later, `bus_clk_en`, `apic_clk_en` and `core_clk_en` are all 0.
- R5: `pll_en` stays at 1 in every state, Sleep included.
- R6: In Sleep the state changes only when `sleep_req` goes low, and `stpclk_req` alone has no effect. When `sleep_req` goes low, the next edge returns to Stop-Grant, and one edge later `bus_clk_en` and `apic_clk_en` go back to 1 while `core_clk_en` stays 0.
- R7: In Stop-Grant with `stpclk_req` low, the next edge returns to Running even if `sleep_req` is high. `core_clk_en` rises one edge after that.
- R8: A strobe bit that is high at an edge while the state is Running or Stop-Grant raises the matching bit of `snoop_ok` or `intr_ok` after that edge, and the bit stays high for exactly one cycle per strobe cycle.
- R9: A strobe bit sampled while the state is Sleep gives no qualified pulse, neither at that time nor after Sleep is left.
- R10: Each clock enable is a registered function of the state that held one edge earlier: bus and interrupt-controller enables are on unless that state was Sleep, and the core enable is on only if it was Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stpclk_req | input | 1 | Stop-clock request, level |
| sleep_req | input | 1 | Sleep request, level |
| snoop_stb | input | SNP_W | Snoop strobes |
| intr_stb | input | INT_W | Interrupt strobes |
| bus_clk_en | output | 1 | Bus unit clock enable |
| apic_clk_en | output | 1 | Interrupt-controller unit clock enable |
| core_clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL enable |
| state_o | output | 2 | Power state: 00 Running, 01 Stop-Grant, 10 Sleep |
| snoop_ok | output | SNP_W | Qualified snoop pulses |
| intr_ok | output | INT_W | Qualified interrupt pulses |

## Verification
A state change shows on `state_o` right after the edge that samples the request. The enables follow one edge after that, and a qualified strobe follows one edge after its input. The bench drives inputs at the falling edge and moves its reference model by one step at each rising edge. It compares every output a short delay after that edge, so each expected value sits exactly as many edges behind its stimulus as there are flops in its path. Directed sequences exercise the transition priorities and the dropped-strobe case, and a seeded random run then covers the other orderings.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_STPG  = 2'b01,
        ST_SLEEP = 2'b10
    } pstate_t;

    typedef struct packed {
        logic bus;
        logic apic;
        logic core;
        logic pll;
    } unit_en_t;

    localparam unit_en_t EN_ALL_ON = '{bus: 1'b1, apic: 1'b1, core: 1'b1, pll: 1'b1};

    // Next power state from the present state and the two request levels.
    function automatic pstate_t next_pstate(pstate_t cur, logic stp, logic slp);
        pstate_t nxt;
        nxt = cur;
        unique case (cur)
            ST_RUN:   nxt = stp ? ST_STPG : ST_RUN;
            ST_STPG:  begin
                if (!stp)      nxt = ST_RUN;
                else if (slp)  nxt = ST_SLEEP;
                else           nxt = ST_STPG;
            end
            ST_SLEEP: nxt = slp ? ST_SLEEP : ST_STPG;
            default:  nxt = ST_RUN;
        endcase
        return nxt;
    endfunction

    // Unit clock enables implied by a power state.
    function automatic unit_en_t enables_for(pstate_t st);
        unit_en_t e;
        e.pll  = 1'b1;
        e.bus  = (st != ST_SLEEP);
        e.apic = (st != ST_SLEEP);
        e.core = (st == ST_RUN);
        return e;
    endfunction

endpackage

// File: rtl/slp_state_fsm.sv
module slp_state_fsm
    import pwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stpclk_req,
    input  logic    sleep_req,
    output pstate_t state
);

    pstate_t state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= next_pstate(state_q, stpclk_req, sleep_req);
    end

    assign state = state_q;

    // Sleep is entered only from Stop-Grant.
    assert_sleep_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && state_q == ST_SLEEP && $past(state_q) != ST_SLEEP)
            |-> $past(state_q) == ST_STPG);

    // Sleep request alone never moves the state out of Running.
    assert_run_ignores_sleep_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !stpclk_req) |=> state_q == ST_RUN);

    // Sleep is held while the sleep request stays high.
    assert_sleep_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && sleep_req) |=> state_q == ST_SLEEP);

    // Releasing stop-clock in Stop-Grant wins over a sleep request.
    assert_stpg_release_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STPG && !stpclk_req) |=> state_q == ST_RUN);

endmodule

// File: rtl/slp_clk_enables.sv
module slp_clk_enables
    import pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pstate_t  state,
    output unit_en_t en
);

    unit_en_t en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= EN_ALL_ON;
        else     en_q <= enables_for(state);
    end

    assign en = en_q;

    assert_pll_on_R5: assert property (@(posedge clk) disable iff (rst)
        en_q.pll == 1'b1);

    assert_core_follows_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> en_q.core == ($past(state) == ST_RUN));

    assert_sleep_gates_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(state) == ST_SLEEP) |-> (!en_q.bus && !en_q.apic && !en_q.core));

endmodule

// File: rtl/slp_event_qual.sv
module slp_event_qual #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_sleep,
    input  logic [W-1:0] stb,
    output logic [W-1:0] ok
);

    logic [W-1:0] ok_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) ok_q[i] <= 1'b0;
            else     ok_q[i] <= stb[i] & ~in_sleep;
        end
    end

    assign ok = ok_q;

    assert_drop_in_sleep_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_sleep)) |-> ok_q == '0);

endmodule

// File: rtl/slp_sleep_ctrl.sv
module slp_sleep_ctrl
    import pwr_pkg::*;
#(
    parameter int SNP_W = 1,
    parameter int INT_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stpclk_req,
    input  logic             sleep_req,
    input  logic [SNP_W-1:0] snoop_stb,
    input  logic [INT_W-1:0] intr_stb,
    output logic             bus_clk_en,
    output logic             apic_clk_en,
    output logic             core_clk_en,
    output logic             pll_en,
    output logic [1:0]       state_o,
    output logic [SNP_W-1:0] snoop_ok,
    output logic [INT_W-1:0] intr_ok
);

    pstate_t  state;
    unit_en_t en;
    logic     in_sleep;

    slp_state_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .stpclk_req (stpclk_req),
        .sleep_req  (sleep_req),
        .state      (state)
    );

    slp_clk_enables u_en (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .en    (en)
    );

    assign in_sleep = (state == ST_SLEEP);

    slp_event_qual #(.W(SNP_W)) u_snoop_q (
        .clk      (clk),
        .rst      (rst),
        .in_sleep (in_sleep),
        .stb      (snoop_stb),
        .ok       (snoop_ok)
    );

    slp_event_qual #(.W(INT_W)) u_intr_q (
        .clk      (clk),
        .rst      (rst),
        .in_sleep (in_sleep),
        .stb      (intr_stb),
        .ok       (intr_ok)
    );

    assign bus_clk_en  = en.bus;
    assign apic_clk_en = en.apic;
    assign core_clk_en = en.core;
    assign pll_en      = en.pll;
    assign state_o     = state;

    // Leaving Sleep always lands in Stop-Grant; bus clock comes back one edge later.
    assert_sleep_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(state) == ST_SLEEP && state == ST_STPG) |=> bus_clk_en && apic_clk_en && !core_clk_en);

endmodule

// File: tb/slp_sleep_ctrl_tb.sv
module slp_sleep_ctrl_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stpclk_req = 1'b0;
    logic       sleep_req = 1'b0;
    logic [0:0] snoop_stb = '0;
    logic [0:0] intr_stb = '0;
    logic       bus_clk_en, apic_clk_en, core_clk_en, pll_en;
    logic [1:0] state_o;
    logic [0:0] snoop_ok, intr_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [1:0] m_state;
    logic       m_bus, m_apic, m_core, m_pll, m_snp, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    slp_sleep_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .stpclk_req  (stpclk_req),
        .sleep_req   (sleep_req),
        .snoop_stb   (snoop_stb),
        .intr_stb    (intr_stb),
        .bus_clk_en  (bus_clk_en),
        .apic_clk_en (apic_clk_en),
        .core_clk_en (core_clk_en),
        .pll_en      (pll_en),
        .state_o     (state_o),
        .snoop_ok    (snoop_ok),
        .intr_ok     (intr_ok)
    );

    function automatic logic [1:0] ref_next(logic [1:0] s, logic stp, logic slp);
        if (s == 2'b00) return stp ? 2'b01 : 2'b00;           // R2 R3
        if (s == 2'b01) return !stp ? 2'b00 : (slp ? 2'b10 : 2'b01); // R4 R7
        return slp ? 2'b10 : 2'b01;                           // R6
    endfunction

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2 R3 R4 R6 R7 state", state_o, m_state);
        check("R10 bus_clk_en", {1'b0, bus_clk_en}, {1'b0, m_bus});
        check("R10 apic_clk_en", {1'b0, apic_clk_en}, {1'b0, m_apic});
        check("R10 core_clk_en", {1'b0, core_clk_en}, {1'b0, m_core});
        check("R5 pll_en", {1'b0, pll_en}, {1'b0, m_pll});
        check("R8 R9 snoop_ok", {1'b0, snoop_ok}, {1'b0, m_snp});
        check("R8 R9 intr_ok", {1'b0, intr_ok}, {1'b0, m_irq});
    endtask

    task automatic cycle(logic stp, logic slp, logic snp, logic irq, logic rs);
        @(negedge clk);
        stpclk_req = stp; sleep_req = slp; snoop_stb = snp; intr_stb = irq; rst = rs;
        @(posedge clk);
        if (rs) begin
            m_state = 2'b00;
            {m_bus, m_apic, m_core, m_pll} = 4'b1111;
            m_snp = 0; m_irq = 0;
        end else begin
            m_bus  = (m_state != 2'b10);
            m_apic = (m_state != 2'b10);
            m_core = (m_state == 2'b00);
            m_pll  = 1'b1;
            m_snp  = snp & (m_state != 2'b10);
            m_irq  = irq & (m_state != 2'b10);
            m_state = ref_next(m_state, stp, slp);
        end
        #1;
        compare_all();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_state = 2'b00;
        {m_bus, m_apic, m_core, m_pll} = 4'b1111;
        m_snp = 0; m_irq = 0;
        cycle(0, 0, 1, 1, 1);
        cycle(0, 0, 0, 0, 1);
        check("R1 reset state", state_o, 2'b00);
        check("R1 reset enables", {bus_clk_en & apic_clk_en, core_clk_en & pll_en}, 2'b11);
        cycle(0, 1, 0, 0, 0);
        check("R3 sleep ignored in Running", state_o, 2'b00);
        cycle(1, 1, 0, 0, 0);
        check("R2 enter Stop-Grant", state_o, 2'b01);
        cycle(1, 0, 0, 0, 0);
        check("R2 core clock off", {1'b0, core_clk_en}, 2'b00);
        check("R2 bus and apic on", {bus_clk_en, apic_clk_en}, 2'b11);
        cycle(1, 1, 1, 0, 0);
        check("R4 enter Sleep", state_o, 2'b10);
        check("R8 snoop pulse from Stop-Grant", {1'b0, snoop_ok}, 2'b01);
        cycle(1, 1, 1, 1, 0);
        check("R4 units gated", {bus_clk_en | apic_clk_en, core_clk_en}, 2'b00);
        check("R5 pll on in Sleep", {1'b0, pll_en}, 2'b01);
        check("R9 strobes dropped", {snoop_ok, intr_ok}, 2'b00);
        cycle(0, 1, 1, 1, 0);
        check("R6 stop-clock ignored in Sleep", state_o, 2'b10);
        cycle(1, 0, 0, 0, 0);
        check("R6 exit to Stop-Grant", state_o, 2'b01);
        check("R9 no late pulse", {snoop_ok, intr_ok}, 2'b00);
        cycle(1, 0, 0, 0, 0);
        check("R6 bus and apic restarted", {bus_clk_en, apic_clk_en}, 2'b11);
        check("R6 core still off", {1'b0, core_clk_en}, 2'b00);
        cycle(0, 1, 0, 1, 0);
        check("R7 release wins over sleep", state_o, 2'b00);
        check("R8 intr pulse", {1'b0, intr_ok}, 2'b01);
        cycle(0, 0, 0, 0, 0);
        check("R7 core clock back", {1'b0, core_clk_en}, 2'b01);
        check("R8 single pulse", {1'b0, intr_ok}, 2'b00);
        cycle(1, 0, 0, 0, 0);
        cycle(1, 1, 0, 0, 0);
        cycle(1, 1, 0, 0, 0);
        cycle(1, 1, 1, 1, 1);
        check("R1 reset from Sleep", state_o, 2'b00);
        check("R1 reset enables from Sleep", {bus_clk_en & apic_clk_en, core_clk_en}, 2'b11);
        check("R1 reset clears pulses", {snoop_ok, intr_ok}, 2'b00);
        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom % 6) != 0, ($urandom % 3) != 0,
                  $urandom % 2, $urandom % 2, ($urandom % 250) == 0);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule